// File: doc/BRIEF.md
# Address-Decoded Accumulating Register Bank

This block holds sixteen 16-bit registers for a processor that has no opcodes and only moves words from one address to another. The bank occupies the top page of the address space. When the upper byte of an address is all ones, the next nibble selects what a store does and the lowest nibble selects the register. A store can replace the register, add the data to it or subtract the data from it. The processor's only instruction is a move, so the choice of destination address decides whether that move acts as an add, a subtract or a plain copy.

Register 15 is the program counter. It can be reached through its ordinary direct address, and also through the all-ones address, which has the reserved operation nibble. The program counter is the only register cleared by reset. The other registers power up with unknown contents.

Every store to one of registers 0 to 14 also appears on an update port in the same cycle, so another unit can keep its own copy of the general registers. Reads return the selected register combinationally. A store takes effect on the next rising clock edge.

Top module: `acc_regbank`

## Requirements
- R1: `hit` is high exactly when addr[15:8] is 8'hFF and it is not the case that addr[7:4] is 4'hF while addr[3:0] differs from 4'hF.
- R2: When `hit` is high, `rdata` equals the register numbered addr[3:0]. When `hit` is low, `rdata` is 16'h0000.
- R3: A store (`wr_en` high with `hit` high) whose operation nibble addr[7:4] is 4'h0 loads `wdata` into the selected register at the clock edge.
- R4: A store with operation nibble 4'h1 sets the selected register to (old + wdata) mod 2^16.
- R5: A store with operation nibble 4'h2 sets the selected register to (old - wdata) mod 2^16.
- R6: A store with an operation nibble from 4'h3 to 4'hE behaves as a direct load of `wdata`.
- R7: Address 16'hFFFF reads and loads register 15, the program counter. A store to an address with operation nibble 4'hF and any register nibble other than 4'hF changes no register.
- R8: After reset, the program counter (register 15) reads as 16'h0000.
- R9: A store to an address whose upper byte is not 8'hFF changes no register.
- R10: During a store that hits register 0 to 14, `upd_valid` is high, `upd_idx` equals the register number and `upd_data` equals the value the register will hold after the edge. `upd_valid` is low for every other cycle, including stores to register 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears only the program counter |
| addr | input | 16 | Address: page byte, operation nibble, register nibble |
| wdata | input | 16 | Store data |
| wr_en | input | 1 | Store strobe |
| rdata | output | 16 | Selected register, or zero when there is no hit |
| hit | output | 1 | Address decodes to this bank |
| upd_valid | output | 1 | A general register is being written this cycle |
| upd_idx | output | 4 | Number of the register being written |
| upd_data | output | 16 | Value that register takes at the edge |

## Verification
`hit`, `rdata` and the update port are combinational. The bench reads them 1 ns after it drives the address, which places each sample before the next rising edge. A register's new value is due one edge after the store. The bench drives each store at a falling edge, lets one rising edge pass, and then reads the register back through a direct-read address at the following falling edge. All 65536 addresses are swept for the decode. The add and subtract modes are driven through their wrap-around values, and the results are compared with a model array in the bench.

// File: rtl/acc_regbank_pkg.sv
package acc_regbank_pkg;
   localparam int unsigned OPC_W = 4;
   typedef enum logic [OPC_W-1:0] {
      OPC_LOAD = 4'h0,
      OPC_ADD  = 4'h1,
      OPC_SUB  = 4'h2,
      OPC_RSV  = 4'hF
   } opc_e;
   typedef enum logic [1:0] {
      ACT_LOAD,
      ACT_ADD,
      ACT_SUB
   } act_e;
endpackage

// File: rtl/acc_regbank_decode.sv
module acc_regbank_decode #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned OP_W   = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output acc_regbank_pkg::act_e act
);
   import acc_regbank_pkg::*;
   localparam int unsigned PAGE_W = ADDR_W - OP_W - IDX_W;

   logic [OP_W-1:0] opc;
   logic            page_ok;
   logic            reserved;

   assign page_ok  = &addr[ADDR_W-1 -: PAGE_W];
   assign opc      = addr[IDX_W +: OP_W];
   assign idx      = addr[IDX_W-1:0];
   assign reserved = (opc == OPC_RSV);
   // the reserved opcode only decodes when it forms the all-ones alias
   assign hit      = page_ok && (!reserved || (&idx));

   always_comb begin
      unique case (opc)
         OPC_ADD: act = ACT_ADD;
         OPC_SUB: act = ACT_SUB;
         default: act = ACT_LOAD;
      endcase
   end
endmodule

// File: rtl/acc_regbank_alu.sv
module acc_regbank_alu #(
   parameter int unsigned DATA_W       = 16,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  acc_regbank_pkg::act_e act,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] new_val
);
   import acc_regbank_pkg::*;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic             neg;
         logic [DATA_W-1:0] opnd_x;
         logic [DATA_W-1:0] sum;
         assign neg    = (act == ACT_SUB);
         assign opnd_x = neg ? ~operand : operand;
         assign sum    = old_val + opnd_x + {{(DATA_W-1){1'b0}}, neg};
         assign new_val = (act == ACT_LOAD) ? operand : sum;
      end else begin : g_split
         logic [DATA_W-1:0] add_r;
         logic [DATA_W-1:0] sub_r;
         assign add_r = old_val + operand;
         assign sub_r = old_val - operand;
         always_comb begin
            unique case (act)
               ACT_ADD: new_val = add_r;
               ACT_SUB: new_val = sub_r;
               default: new_val = operand;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/acc_regbank_store.sv
module acc_regbank_store #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 4,
   localparam int unsigned NREG   = 1 << IDX_W,
   localparam int unsigned PC_IDX = NREG - 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       widx,
   input  logic [DATA_W-1:0]      wval,
   output logic [NREG*DATA_W-1:0] q_flat
);
   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         logic [DATA_W-1:0] r;
         logic              sel;
         assign sel = we && (widx == IDX_W'(i));
         if (i == PC_IDX) begin : g_pc
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   r <= '0;
               else if (sel) r <= wval;
            end
         end else begin : g_gp
            always_ff @(posedge clk) begin
               if (sel) r <= wval;
            end
         end
         assign q_flat[i*DATA_W +: DATA_W] = r;
      end
   endgenerate
endmodule

// File: rtl/acc_regbank.sv
module acc_regbank #(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned IDX_W        = 4,
   parameter int unsigned OP_W         = 4,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rdata,
   output logic              hit,
   output logic              upd_valid,
   output logic [IDX_W-1:0]  upd_idx,
   output logic [DATA_W-1:0] upd_data
);
   import acc_regbank_pkg::*;
   localparam int unsigned NREG   = 1 << IDX_W;
   localparam int unsigned PC_IDX = NREG - 1;

   generate
      if (OP_W != acc_regbank_pkg::OPC_W) begin : g_bad_op
         $error("acc_regbank: OP_W must match the package opcode width");
      end
      if (ADDR_W <= OP_W + IDX_W) begin : g_bad_addr
         $error("acc_regbank: ADDR_W leaves no page-select bits");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("acc_regbank: DATA_W too small");
      end
   endgenerate

   logic [IDX_W-1:0]       idx;
   act_e                   act;
   logic                   we;
   logic [DATA_W-1:0]      cur_val;
   logic [DATA_W-1:0]      nxt_val;
   logic [NREG*DATA_W-1:0] bank_flat;

   acc_regbank_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OP_W(OP_W)) u_dec (
      .addr(addr), .hit(hit), .idx(idx), .act(act)
   );

   assign cur_val = bank_flat[idx*DATA_W +: DATA_W];

   acc_regbank_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .act(act), .old_val(cur_val), .operand(wdata), .new_val(nxt_val)
   );

   assign we = wr_en && hit;

   acc_regbank_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(we), .widx(idx), .wval(nxt_val),
      .q_flat(bank_flat)
   );

   assign rdata     = hit ? cur_val : '0;
   assign upd_valid = we && (idx != IDX_W'(PC_IDX));
   assign upd_idx   = idx;
   assign upd_data  = nxt_val;
endmodule

// File: rtl/acc_regbank_chk.sv
module acc_regbank_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 4,
   localparam int unsigned NREG   = 1 << IDX_W
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      addr,
   input logic [DATA_W-1:0]      wdata,
   input logic                   wr_en,
   input logic [DATA_W-1:0]      rdata,
   input logic                   hit,
   input logic                   upd_valid,
   input logic [IDX_W-1:0]       upd_idx,
   input logic [DATA_W-1:0]      upd_data,
   input logic [NREG*DATA_W-1:0] bank
);
   function automatic logic [DATA_W-1:0] pick(input logic [NREG*DATA_W-1:0] f,
                                              input logic [IDX_W-1:0] i);
      return f[i*DATA_W +: DATA_W];
   endfunction

   logic [IDX_W-1:0] ri;
   logic [3:0]       op;
   logic             st;
   assign ri = addr[IDX_W-1:0];
   assign op = addr[IDX_W +: 4];
   assign st = wr_en && hit;

   a_r1_page_only: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (&addr[ADDR_W-1 -: 8]));
   a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (rdata == '0));
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      (st && op == 4'h0) |=> pick(bank, $past(ri)) == $past(wdata));
   a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
      (st && op == 4'h1) |=> pick(bank, $past(ri)) == DATA_W'($past(pick(bank, ri)) + $past(wdata)));
   a_r5_sub: assert property (@(posedge clk) disable iff (!rst_n)
      (st && op == 4'h2) |=> pick(bank, $past(ri)) == DATA_W'($past(pick(bank, ri)) - $past(wdata)));
   a_r6_other_load: assert property (@(posedge clk) disable iff (!rst_n)
      (st && op >= 4'h3 && op <= 4'hE) |=> pick(bank, $past(ri)) == $past(wdata));
   a_r7_pc_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 16'hFFFF) |=> pick(bank, IDX_W'(NREG-1)) == $past(wdata));
   a_r8_pc_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> pick(bank, IDX_W'(NREG-1)) == '0);
   a_r9_no_store_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !st |=> $stable(bank));
   a_r10_upd_gate: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (st && upd_idx == ri && ri != IDX_W'(NREG-1)));
   a_r10_upd_value: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> pick(bank, $past(upd_idx)) == $past(upd_data));
endmodule

bind acc_regbank acc_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
   .rdata(rdata), .hit(hit), .upd_valid(upd_valid), .upd_idx(upd_idx),
   .upd_data(upd_data), .bank(bank_flat)
);

// File: tb/acc_regbank_test.sv
module acc_regbank_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic [15:0] wdata = 16'h0000;
   logic        wr_en = 1'b0;
   logic [15:0] rdata;
   logic        hit;
   logic        upd_valid;
   logic [3:0]  upd_idx;
   logic [15:0] upd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [15:0] model [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_regbank uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rdata(rdata), .hit(hit), .upd_valid(upd_valid), .upd_idx(upd_idx),
      .upd_data(upd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit exp_hit(input logic [15:0] a);
      return (a[15:8] == 8'hFF) && !(a[7:4] == 4'hF && a[3:0] != 4'hF);
   endfunction

   // store with model update and update-port check (R10)
   task automatic store(input logic [15:0] a, input logic [15:0] d);
      logic [15:0] nv;
      logic [3:0]  r;
      bit          h;
      r = a[3:0];
      h = exp_hit(a);
      case (a[7:4])
         4'h1:    nv = model[r] + d;
         4'h2:    nv = model[r] - d;
         default: nv = d;
      endcase
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      #1;
      chk("R10 upd_valid", {31'd0, upd_valid}, {31'd0, h && r != 4'hF});
      if (h && r != 4'hF) begin
         chk("R10 upd_idx", {28'd0, upd_idx}, {28'd0, r});
         chk("R10 upd_data", {16'd0, upd_data}, {16'd0, nv});
      end
      if (h) model[r] = nv;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_chk(input string req, input logic [3:0] r);
      @(negedge clk);
      addr = {8'hFF, 4'h0, r}; wr_en = 1'b0;
      #1;
      chk(req, {16'd0, rdata}, {16'd0, model[r]});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: PC cleared by reset, seen through both addresses
      model[15] = 16'h0000;
      addr = 16'hFFFF; #1;
      chk("R8 pc via alias", {16'd0, rdata}, 32'd0);
      read_chk("R8 pc direct", 4'hF);

      // R3: direct load of every register
      for (int i = 0; i < 16; i++)
         store({8'hFF, 4'h0, 4'(i)}, 16'(i * 16'h1111) ^ 16'hA5C3);
      for (int i = 0; i < 16; i++) read_chk("R3 load readback", 4'(i));

      // R1/R2: full decode sweep, no stores
      @(negedge clk);
      for (int a = 0; a < 65536; a++) begin
         addr = 16'(a); #1;
         chk("R1 hit decode", {31'd0, hit}, {31'd0, exp_hit(16'(a))});
         if (exp_hit(16'(a)))
            chk("R2 read selected", {16'd0, rdata}, {16'd0, model[a[3:0]]});
         else
            chk("R2 miss reads zero", {16'd0, rdata}, 32'd0);
      end

      // R4: add, including wrap
      store(16'hFF03, 16'hFFFF);
      store(16'hFF13, 16'h0002);
      chk("R4 wrap model", {16'd0, model[3]}, 32'h0001);
      read_chk("R4 add wrap", 4'h3);
      for (int i = 0; i < 15; i++) begin
         for (int k = 0; k < 4; k++) store({8'hFF, 4'h1, 4'(i)}, 16'(k * 16'h3F01 + i));
         read_chk("R4 add sweep", 4'(i));
      end

      // R5: subtract, including wrap below zero
      store(16'hFF04, 16'h0000);
      store(16'hFF24, 16'h0001);
      chk("R5 wrap model", {16'd0, model[4]}, 32'hFFFF);
      read_chk("R5 sub wrap", 4'h4);
      for (int i = 0; i < 15; i++) begin
         for (int k = 0; k < 4; k++) store({8'hFF, 4'h2, 4'(i)}, 16'(k * 16'h1207 + 3 * i));
         read_chk("R5 sub sweep", 4'(i));
      end

      // R6: opcodes 3..E load directly
      for (int o = 3; o < 15; o++) begin
         store({8'hFF, 4'(o), 4'(o - 2)}, 16'(o * 16'h0B0D));
         read_chk("R6 other opcode loads", 4'(o - 2));
      end

      // R7: PC alias load, add to PC, reserved opcode ignored
      store(16'hFFFF, 16'h1234);
      read_chk("R7 alias load", 4'hF);
      store(16'hFF1F, 16'h0010);
      read_chk("R7 add to pc", 4'hF);
      for (int i = 0; i < 15; i++) begin
         store({8'hFF, 4'hF, 4'(i)}, 16'hDEAD);
         read_chk("R7 reserved ignored", 4'(i));
      end

      // R9: stores off the page change nothing
      store(16'hFE03, 16'h5555);
      store(16'h7F13, 16'h5555);
      store(16'h00FF, 16'h5555);
      store(16'hEFF2, 16'h5555);
      for (int i = 0; i < 16; i++) read_chk("R9 miss store ignored", 4'(i));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule